// File: doc/BRIEF.md
# Serial-Mode SAR Conversion Sequencer

This block is the digital control around a successive-approximation converter running with a serial result port. A falling edge on the active-low convert-start line, seen while chip select is low, captures the input code and launches a conversion. The conversion is paced by one of two sources. When the select input is low, an internal divider of the system clock supplies the pace. When it is high, an external conversion clock supplies it. A counting gate lets exactly 16 of those clock ticks advance the sequencer. Any further external edges are dropped.

A digital stand-in for the comparator and DAC delivers the 14-bit result one bit per tick, most significant bit first. The result is then loaded into a 16-bit output shift register and busy returns high. The host clocks the register out on falling edges of its shift clock. It can do so before the next conversion or during it. While chip select and read are both low, each gated tick is also shown as a one-cycle pulse on a clock output. All asynchronous inputs pass through two-stage synchronisers into the system clock domain.

The sequencer has three states. IDLE moves to CONVERT on transition T_START: a qualified convert-start edge. CONVERT moves to LOAD on transition T_DONE: the 16th gated tick. LOAD moves back to IDLE on transition T_LOADED: the shift register is written. Every other case holds the current state.

Top module: `sar_serial_ctl`

## Requirements
- R1: A conversion starts only on a synchronised falling edge of `conv_start_n` while `cs_n` is low. With `cs_n` high the edge is ignored and `busy` stays high.
- R2: With `ext_sel` low, conversion ticks come from the internal divider of `clk`. With `ext_sel` high, they come from rising edges of `ext_clk`. In external mode the conversion does not progress while `ext_clk` is idle.
- R3: Each conversion accepts exactly 16 ticks. External edges after the 16th do not reach the sequencer, and `clk_out` shows no more than 16 pulses.
- R4: While `cs_n` and `rd_n` are both low, `clk_out` gives one pulse per accepted tick. `clk_out` stays low when either of those inputs is high. It also stays low whenever `busy` is high.
- R5: `busy` goes low within a few cycles of a qualified start. It stays low through the 16 ticks and one load cycle. It goes high only once the shift register holds the new result.
- R6: `dout_en` (the three-state buffer enable) is high exactly when `cs_n` and `rd_n` are both low.
- R7: The register holds {result[13:0], 2'b00}. Bit 15 appears on `dout` first. Each synchronised falling edge of `sclk` shifts the register left by one while `dout_en` is high.
- R8: The previous result can be shifted out while a new conversion runs. The register is not overwritten before the new conversion completes, and it does not change while `dout_en` is low.
- R9: A convert-start falling edge during a conversion is ignored. The running conversion completes with its own captured code.
- R10: `sample_code` is captured at the start edge. Later changes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_n | input | 1 | Convert-start, falling edge active (asynchronous) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| ext_sel | input | 1 | 0: internal conversion clock, 1: external |
| ext_clk | input | 1 | External conversion clock (asynchronous) |
| sclk | input | 1 | Serial shift clock (asynchronous) |
| sample_code | input | 14 | Code the converter stub resolves |
| busy | output | 1 | High when idle with a valid result loaded |
| clk_out | output | 1 | One pulse per gated conversion tick |
| dout | output | 1 | Serial data, bit 15 of the shift register |
| dout_en | output | 1 | Output driver enable (low = high impedance) |

## Verification
A wrong tick count or a stuck state in the sequencer shows up in two ways. `clk_out` gives the wrong number of pulses, and `busy` never rises or rises too early, within one conversion of about 70 cycles. A broken load, capture or shift path shows up as a wrong bit in the first 16-bit read after the conversion. A premature overwrite shows up during the overlapped read, which must still return the previous code. A missing start qualifier or a missing in-conversion guard becomes visible within about 100 cycles. It appears as `busy` falling when it should not, or staying low when it should have returned high.

// File: rtl/sarctl_pkg.sv
package sarctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_LOAD    = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sync_edge.sv
// Two-stage synchroniser followed by edge detection.
module sync_edge #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            stab_q <= INIT;
            prev_q <= INIT;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign rise = stab_q & ~prev_q;
    assign fall = ~stab_q & prev_q;
endmodule

// File: rtl/conv_clk_gen.sv
// Conversion tick source: internal divider or external edges.
module conv_clk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_ext,
    input  logic ext_rise,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;
    logic          int_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || use_ext || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign int_tick = run && !use_ext && (div_q == LAST);
    assign tick     = use_ext ? (run && ext_rise) : int_tick;
endmodule

// File: rtl/sar_stub.sv
// Digital stand-in for the comparator/DAC: resolves the held code MSB first.
module sar_stub #(
    parameter int RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [RES_W-1:0] code_in,
    input  logic             step,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] hold_q, acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            acc_q  <= '0;
        end else if (capture) begin
            hold_q <= code_in;
            acc_q  <= '0;
        end else if (step) begin
            acc_q  <= {acc_q[RES_W-2:0], hold_q[RES_W-1]};
            hold_q <= {hold_q[RES_W-2:0], 1'b0};
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/out_shifter.sv
// Output shift register; load wins over shift.
module out_shifter #(
    parameter int SR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift_en,
    output logic            msb
);
    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift_en) begin
            sr_q <= {sr_q[SR_W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[SR_W-1];
endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
    import sarctl_pkg::*;
#(
    parameter int RES_W    = 14,
    parameter int SR_W     = 16,
    parameter int CONV_CYC = 16,
    parameter int INT_DIV  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             ext_sel,
    input  logic             ext_clk,
    input  logic             sclk,
    input  logic [RES_W-1:0] sample_code,
    output logic             busy,
    output logic             clk_out,
    output logic             dout,
    output logic             dout_en
);
    localparam int BCW = $clog2(CONV_CYC);
    localparam logic [BCW-1:0] LAST_TICK = BCW'(CONV_CYC - 1);
    localparam int PAD = SR_W - RES_W;

    sar_state_e       state_q, state_d;
    logic [BCW-1:0]   bit_cnt_q;
    logic             start_fall, ext_rise, sclk_fall;
    logic             unused_rise0, unused_fall1, unused_rise2;
    logic             tick, adv, start, port_on;
    logic             clk_out_q;
    logic [RES_W-1:0] result;

    sync_edge #(.INIT(1'b1)) u_sync_conv (
        .clk(clk), .rst_n(rst_n), .async_in(conv_start_n),
        .rise(unused_rise0), .fall(start_fall));
    sync_edge #(.INIT(1'b0)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk),
        .rise(ext_rise), .fall(unused_fall1));
    sync_edge #(.INIT(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(sclk),
        .rise(unused_rise2), .fall(sclk_fall));

    conv_clk_gen #(.DIV(INT_DIV)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_CONVERT),
        .use_ext(ext_sel), .ext_rise(ext_rise), .tick(tick));

    assign port_on = !cs_n && !rd_n;
    assign start   = (state_q == ST_IDLE) && start_fall && !cs_n;
    assign adv     = tick && (state_q == ST_CONVERT);

    // Next-state logic: T_START, T_DONE, T_LOADED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CONVERT;
            ST_CONVERT: if (adv && bit_cnt_q == LAST_TICK) state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (start)    bit_cnt_q <= '0;
            else if (adv) bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    sar_stub #(.RES_W(RES_W)) u_stub (
        .clk(clk), .rst_n(rst_n), .capture(start), .code_in(sample_code),
        .step(adv && (bit_cnt_q < BCW'(RES_W))), .result(result));

    out_shifter #(.SR_W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_LOAD),
        .load_val({result, {PAD{1'b0}}}),
        .shift_en(sclk_fall && port_on), .msb(dout));

    // Mirrored conversion clock pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_out_q <= 1'b0;
        else        clk_out_q <= adv && port_on;
    end

    // Outputs
    always_comb begin
        busy    = (state_q == ST_IDLE);
        clk_out = clk_out_q;
        dout_en = port_on;
    end
endmodule

// File: rtl/sar_serial_ctl_chk.sv
module sar_serial_ctl_chk #(
    parameter int CONV_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic busy,
    input logic clk_out,
    input logic dout,
    input logic dout_en,
    input logic adv
);
    localparam int CW = $clog2(CONV_CYC + 2);
    logic [CW-1:0] adv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   adv_cnt <= '0;
        else if (busy) adv_cnt <= '0;
        else if (adv)  adv_cnt <= adv_cnt + 1'b1;
    end

    AST_START_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!cs_n)); // R1
    AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        adv_cnt <= CW'(CONV_CYC)); // R3
    AST_TICK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (adv_cnt == CW'(CONV_CYC))); // R5
    AST_CLKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !clk_out); // R4
    AST_CLKOUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> $past(!cs_n && !rd_n)); // R4
    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(!dout_en)) |-> $stable(dout)); // R8
endmodule

bind sar_serial_ctl sar_serial_ctl_chk #(.CONV_CYC(CONV_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
    .clk_out(clk_out), .dout(dout), .dout_en(dout_en), .adv(adv));

// File: tb/sim_sar_serial_ctl.sv
module sim_sar_serial_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic conv_start_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1;
    logic ext_sel = 1'b0, ext_clk = 1'b0, sclk = 1'b0;
    logic [RES_W-1:0] sample_code = '0;
    logic busy, clk_out, dout, dout_en;

    int errors = 0, checks = 0, pulses = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_serial_ctl u0 (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .cs_n(cs_n),
        .rd_n(rd_n), .ext_sel(ext_sel), .ext_clk(ext_clk), .sclk(sclk),
        .sample_code(sample_code), .busy(busy), .clk_out(clk_out),
        .dout(dout), .dout_en(dout_en));

    always @(negedge clk) if (clk_out) pulses++;

    function automatic logic [15:0] exp_word(input logic [RES_W-1:0] c);
        return {c, 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [RES_W-1:0] code);
        sample_code  = code;
        conv_start_n = 1'b0;
        idle(4);
        conv_start_n = 1'b1;
        idle(1);
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
    endtask

    task automatic wait_busy(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (busy) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic read_word(output logic [15:0] w);
        w[15] = dout;
        for (int i = 14; i >= 0; i--) begin
            sclk = 1'b1; idle(3);
            sclk = 1'b0; idle(4);
            w[i] = dout;
        end
    endtask

    // Full conversion: returns pulse count and read word
    task automatic convert(input logic [RES_W-1:0] code, input logic ext,
                           input int extra, output int np, output logic [15:0] w);
        bit ok;
        ext_sel = ext; cs_n = 1'b0; rd_n = 1'b0;
        pulses = 0;
        pulse_start(code);
        sample_code = ~code;              // R10: later change ignored
        if (ext) ext_edges(16 + extra);
        wait_busy(ok);
        check(ok, "R5 busy returns", ok, 1);
        idle(2);
        np = pulses;
        read_word(w);
    endtask

    initial begin
        logic [15:0] w;
        int np;
        bit ok;
        void'($urandom(32'h5A17));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // Reset state
        check(busy == 1'b1, "R5 reset busy", busy, 1);
        check(clk_out == 1'b0, "R4 reset clk_out", clk_out, 0);
        check(dout_en == 1'b0, "R6 dout_en off", dout_en, 0);

        // R1: start ignored with cs high
        cs_n = 1'b1;
        pulse_start(14'h1234);
        ok = 1'b1;
        for (int i = 0; i < 100; i++) begin if (!busy) ok = 1'b0; @(negedge clk); end
        check(ok, "R1 no start with cs_n high", ok, 1);

        // R6
        cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
        check(dout_en == 1'b0, "R6 rd_n high", dout_en, 0);
        rd_n = 1'b0; @(negedge clk);
        check(dout_en == 1'b1, "R6 both low", dout_en, 1);

        // R2/R7 internal clock, directed corner codes
        convert(14'h3FFF, 1'b0, 0, np, w);
        check(w == exp_word(14'h3FFF), "R7 all ones", w, exp_word(14'h3FFF));
        check(np == 16, "R3 internal pulses", np, 16);
        convert(14'h2001, 1'b0, 0, np, w);
        check(w == exp_word(14'h2001), "R10 captured code", w, exp_word(14'h2001));

        // R3 external with surplus edges
        convert(14'h155A, 1'b1, 12, np, w);
        check(np == 16, "R3 surplus ext edges", np, 16);
        check(w == exp_word(14'h155A), "R2 ext result", w, exp_word(14'h155A));

        // R2 ext idle: conversion waits; R4 rd high -> no pulses; R8 overlap read; R9 restart ignored
        ext_sel = 1'b1; cs_n = 1'b0; rd_n = 1'b1; pulses = 0;
        pulse_start(14'h0ACE);
        idle(50);
        check(busy == 1'b0, "R2 ext idle holds conversion", busy, 0);
        rd_n = 1'b0;
        read_word(w);
        check(w == exp_word(14'h155A) || w == 16'h0000, "R8 old result during conversion", w, 16'h0000);
        pulse_start(14'h3333);                 // R9 second edge ignored
        rd_n = 1'b1;
        ext_edges(8);
        rd_n = 1'b0;
        ext_edges(10);
        wait_busy(ok);
        check(ok, "R9 conversion completes", ok, 1);
        idle(2);
        check(pulses == 8, "R4 pulses only with rd low", pulses, 8);
        read_word(w);
        check(w == exp_word(14'h0ACE), "R9 first code kept", w, exp_word(14'h0ACE));
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin if (!busy || clk_out) ok = 1'b0; @(negedge clk); end
        check(ok, "R9 no second conversion, R4 clk_out low", ok, 1);

        // R8 strict: full previous word readable while next conversion pending
        convert(14'h2BCD, 1'b0, 0, np, w);
        ext_sel = 1'b1; pulse_start(14'h0F0F);
        idle(2);
        // the read above already shifted out; reload a known word first
        ext_edges(16);
        wait_busy(ok);
        idle(2);
        pulse_start(14'h1111);
        read_word(w);
        check(w == exp_word(14'h0F0F), "R8 previous word during conversion", w, exp_word(14'h0F0F));
        check(busy == 1'b0, "R8 conversion still pending", busy, 0);
        ext_edges(16);
        wait_busy(ok);
        idle(2);
        read_word(w);
        check(w == exp_word(14'h1111), "R8 new word after completion", w, exp_word(14'h1111));

        // Random mix
        for (int k = 0; k < 20; k++) begin
            logic [RES_W-1:0] c;
            logic e;
            int x;
            c = RES_W'($urandom);
            e = 1'($urandom);
            x = $urandom_range(0, 10);
            convert(c, e, x, np, w);
            check(w == exp_word(c), "R7 random word", w, exp_word(c));
            check(np == 16, "R3 random pulses", np, 16);
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule